// File: doc/BRIEF.md
# LRU Set-Associative Cache Tag Simulator

This block models only the tag state of a two-level, write-allocate, set-associative cache. It takes a trace of memory references and reports for each one whether it hits or misses. It never stores data. A trace source presents a byte address and an access length on a valid/ready request port. The first level looks the reference up in its tag store and updates that store. A reference that misses in the first level is passed, with the same address and length, to a larger last-level instance. When the reference is resolved, a single-cycle response pulse reports both outcomes. Saturating counters keep totals that a profiling harness can read.

Each set keeps its ways in strict recency order: way 0 holds the most recent tag and the last way holds the least recent. The ways are physically shifted on every update. A reference whose bytes run into the following line is treated as one access. Both sets are looked up and updated, one per clock, and the access counts as a miss if either line misses. A reference whose bytes cover more than two lines is rejected with an error pulse.

Top module: `lru_tag_sim`

## Requirements
- R1: For each level, sets = size / line bytes / ways. The set index is the address bits just above the line offset, taken as log2(sets) bits. The tag is all address bits above the index.
- R2: Reset clears every tag in every way to zero, so an address with a zero tag hits straight after reset. Reset also clears all counters to zero and raises req_ready.
- R3: A hit in way i moves ways 0..i-1 down by one and writes the hit tag into way 0. A hit in way 0 leaves the set unchanged.
- R4: A miss, whether a read or a write, shifts every way down by one. It drops the tag in the last way and writes the new tag into way 0.
- R5: If the last byte (address + length - 1) lies in the set after the first byte's set (modulo the set count), both lines are looked up and updated. The second line uses the tag of the last byte. The access counts once, and as a miss if either line misses. A length of zero is treated as one byte.
- R6: If the last byte's set is neither the first set nor the next one, rsp_err pulses for one cycle. In that case rsp_valid stays low, no counter changes and the last level is not consulted.
- R7: A first-level miss increments l1_miss_cnt and presents the same reference to the last level. A miss there increments ll_miss_cnt. Every resolved reference increments l1_access_cnt.
- R8: req_ready is low while a level performs the second lookup of a line-crossing reference, and in the cycle in which a first-level miss is handed on. It is high again in the cycle that reports a first-level hit.
- R9: rsp_valid is due 1 cycle after acceptance for a single-line first-level hit, and 2 cycles after for a line-crossing first-level hit. A first-level miss adds 1 cycle for a single-line last-level lookup, or 2 cycles for a line-crossing one.
- R10: The counters are CNT_W bits wide. They never decrease, and they hold at all-ones instead of wrapping.
- R11: When rsp_valid is high, rsp_l1_hit=1 marks a first-level hit, and rsp_ll_hit is then 0. rsp_l1_hit=0 with rsp_ll_hit=1 marks a first-level miss that hit in the last level. Both low marks a miss in both levels. Both flags are 0 whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Reference offered |
| req_ready | output | 1 | Reference accepted when high with req_valid |
| req_addr | input | ADDR_W | Byte address of first byte |
| req_size | input | SIZE_W | Access length in bytes |
| rsp_valid | output | 1 | One-cycle pulse: reference resolved |
| rsp_l1_hit | output | 1 | First level hit |
| rsp_ll_hit | output | 1 | Last level hit after a first-level miss |
| rsp_err | output | 1 | One-cycle pulse: reference spans more than two sets |
| l1_access_cnt | output | CNT_W | Resolved references |
| l1_miss_cnt | output | CNT_W | First-level misses |
| ll_miss_cnt | output | CNT_W | Last-level misses |

## Verification
Each tag-store update is registered, so a level's outcome is visible one cycle after each lookup. That gives a response 1, 2, 3 or 4 cycles after acceptance, depending on line crossing and on whether the reference is forwarded. The error pulse is due one cycle after acceptance. Every vector carries its expected latency. The bench counts falling edges from the accepting edge until the pulse and compares that count. It also samples req_ready on the first falling edge after acceptance. Counter values are read on the falling edge after the response, which is one register stage later.

// File: rtl/lts_pkg.sv
package lts_pkg;

    typedef enum logic {
        LVL_IDLE   = 1'b0,
        LVL_SECOND = 1'b1
    } lvl_state_e;

    function automatic bit lts_is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/lts_tag_store.sv
module lts_tag_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        wr_en,
    input  logic [WAYS-1:0][TAG_W-1:0]  wr_row,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_row
);

    logic [WAYS-1:0][TAG_W-1:0] mem_d [SETS];
    logic [WAYS-1:0][TAG_W-1:0] mem_q [SETS];

    assign rd_row = mem_q[idx];

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            mem_d[s] = mem_q[s];
        end
        if (wr_en) begin
            mem_d[idx] = wr_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                mem_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                mem_q[s] <= mem_d[s];
            end
        end
    end

endmodule

// File: rtl/lts_lru_update.sv
module lts_lru_update #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row_in,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAYS-1:0][TAG_W-1:0] row_out
);

    if (WAYS == 1) begin : g_direct
        // direct-mapped: the only way is overwritten, nothing shifts
        always_comb begin
            hit        = (row_in[0] == tag);
            row_out[0] = tag;
        end
    end else begin : g_assoc
        localparam int WAY_W = $clog2(WAYS);
        logic [WAY_W-1:0] pos;

        always_comb begin
            hit = 1'b0;
            pos = WAY_W'(WAYS - 1);
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (row_in[w] == tag) begin
                    hit = 1'b1;
                    pos = WAY_W'(w);
                end
            end
            row_out[0] = tag;
            for (int w = 1; w < WAYS; w++) begin
                row_out[w] = (WAY_W'(w) <= pos) ? row_in[w-1] : row_in[w];
            end
        end
    end

endmodule

// File: rtl/lts_level.sv
module lts_level
    import lts_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 8,
    parameter int SIZE_B = 1024,
    parameter int LINE_B = 32,
    parameter int WAYS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [SIZE_W-1:0] in_size,
    output logic              out_done,
    output logic              out_miss,
    output logic              out_err
);

    localparam int SETS  = SIZE_B / LINE_B / WAYS;
    localparam int OFF_W = $clog2(LINE_B);
    localparam int IDX_W = $clog2(SETS);
    localparam int LN_W  = ADDR_W - OFF_W;
    localparam int TAG_W = LN_W - IDX_W;

    if (!lts_is_pow2(SIZE_B) || !lts_is_pow2(LINE_B) || !lts_is_pow2(WAYS)) begin : g_bad_pow2
        $error("cache geometry parameters must be powers of two");
    end
    if (SETS < 2 || !lts_is_pow2(SETS)) begin : g_bad_sets
        $error("set count must be a power of two of at least 2");
    end
    if (TAG_W < 1 || SIZE_W >= ADDR_W) begin : g_bad_width
        $error("address too narrow for this geometry");
    end

    typedef struct packed {
        lvl_state_e      st;
        logic [LN_W-1:0] last_line;
        logic            miss1;
        logic            done;
        logic            miss;
        logic            err;
    } lvl_s;

    lvl_s lvl_d, lvl_q;

    logic [ADDR_W-1:0]           last_addr;
    logic [LN_W-1:0]             first_line;
    logic [LN_W-1:0]             lk_line;
    logic [IDX_W-1:0]            lk_idx;
    logic [TAG_W-1:0]            lk_tag;
    logic [IDX_W-1:0]            set_first;
    logic [IDX_W-1:0]            set_last;
    logic                        wr_en;
    logic                        hit;
    logic [WAYS-1:0][TAG_W-1:0]  row_rd;
    logic [WAYS-1:0][TAG_W-1:0]  row_wr;

    always_comb begin
        last_addr  = in_addr + ADDR_W'(in_size) - ADDR_W'(in_size != '0);
        first_line = LN_W'(in_addr >> OFF_W);
        lk_line    = (lvl_q.st == LVL_SECOND) ? lvl_q.last_line : first_line;
        lk_idx     = lk_line[IDX_W-1:0];
        lk_tag     = lk_line[LN_W-1:IDX_W];
        set_first  = first_line[IDX_W-1:0];
        set_last   = IDX_W'(LN_W'(last_addr >> OFF_W));
    end

    lts_tag_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (lk_idx),
        .wr_en  (wr_en),
        .wr_row (row_wr),
        .rd_row (row_rd)
    );

    lts_lru_update #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_update (
        .row_in  (row_rd),
        .tag     (lk_tag),
        .hit     (hit),
        .row_out (row_wr)
    );

    assign in_ready = (lvl_q.st == LVL_IDLE);
    assign out_done = lvl_q.done;
    assign out_miss = lvl_q.miss;
    assign out_err  = lvl_q.err;

    always_comb begin
        lvl_d      = lvl_q;
        lvl_d.done = 1'b0;
        lvl_d.miss = 1'b0;
        lvl_d.err  = 1'b0;
        wr_en      = 1'b0;
        case (lvl_q.st)
            LVL_IDLE: begin
                if (in_valid) begin
                    if (set_last == set_first) begin
                        wr_en      = 1'b1;
                        lvl_d.done = 1'b1;
                        lvl_d.miss = !hit;
                    end else if (set_last == set_first + 1'b1) begin
                        wr_en           = 1'b1;
                        lvl_d.st        = LVL_SECOND;
                        lvl_d.last_line = LN_W'(last_addr >> OFF_W);
                        lvl_d.miss1     = !hit;
                    end else begin
                        lvl_d.err = 1'b1;
                    end
                end
            end
            LVL_SECOND: begin
                wr_en      = 1'b1;
                lvl_d.st   = LVL_IDLE;
                lvl_d.done = 1'b1;
                lvl_d.miss = lvl_q.miss1 | !hit;
            end
            default: lvl_d.st = LVL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '{st: LVL_IDLE, default: '0};
        end else begin
            lvl_q <= lvl_d;
        end
    end

endmodule

// File: rtl/lts_sat_counter.sv
module lts_sat_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc && (count_q != '1)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/lru_tag_sim.sv
module lru_tag_sim #(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 8,
    parameter int L1_SIZE_B = 1024,
    parameter int L1_LINE_B = 32,
    parameter int L1_WAYS   = 2,
    parameter int LL_SIZE_B = 8192,
    parameter int LL_LINE_B = 64,
    parameter int LL_WAYS   = 8,
    parameter int CNT_W     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              rsp_valid,
    output logic              rsp_l1_hit,
    output logic              rsp_ll_hit,
    output logic              rsp_err,
    output logic [CNT_W-1:0]  l1_access_cnt,
    output logic [CNT_W-1:0]  l1_miss_cnt,
    output logic [CNT_W-1:0]  ll_miss_cnt
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
    } pend_s;

    pend_s pend_d, pend_q;

    logic l1_ready, l1_done, l1_miss, l1_err;
    logic ll_ready, ll_done, ll_miss, ll_err;
    logic l1_fwd;
    logic req_fire;

    assign l1_fwd    = l1_done & l1_miss;
    assign req_ready = l1_ready & ll_ready & !l1_fwd;
    assign req_fire  = req_valid & req_ready;

    lts_level #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .SIZE_B (L1_SIZE_B),
        .LINE_B (L1_LINE_B),
        .WAYS   (L1_WAYS)
    ) u_l1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_fire),
        .in_ready (l1_ready),
        .in_addr  (req_addr),
        .in_size  (req_size),
        .out_done (l1_done),
        .out_miss (l1_miss),
        .out_err  (l1_err)
    );

    lts_level #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .SIZE_B (LL_SIZE_B),
        .LINE_B (LL_LINE_B),
        .WAYS   (LL_WAYS)
    ) u_ll (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (l1_fwd),
        .in_ready (ll_ready),
        .in_addr  (pend_q.addr),
        .in_size  (pend_q.size),
        .out_done (ll_done),
        .out_miss (ll_miss),
        .out_err  (ll_err)
    );

    always_comb begin
        pend_d = pend_q;
        if (req_fire) begin
            pend_d.addr = req_addr;
            pend_d.size = req_size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign rsp_valid  = (l1_done & !l1_miss) | ll_done;
    assign rsp_l1_hit = l1_done & !l1_miss;
    assign rsp_ll_hit = ll_done & !ll_miss;
    assign rsp_err    = l1_err | ll_err;

    lts_sat_counter #(.W(CNT_W)) u_cnt_l1_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (l1_done),
        .count (l1_access_cnt)
    );

    lts_sat_counter #(.W(CNT_W)) u_cnt_l1_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (l1_fwd),
        .count (l1_miss_cnt)
    );

    lts_sat_counter #(.W(CNT_W)) u_cnt_ll_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ll_done & ll_miss),
        .count (ll_miss_cnt)
    );

endmodule

// File: rtl/lts_checker.sv
module lts_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_l1_hit,
    input logic             rsp_ll_hit,
    input logic             rsp_err,
    input logic [CNT_W-1:0] l1_access_cnt,
    input logic [CNT_W-1:0] l1_miss_cnt,
    input logic [CNT_W-1:0] ll_miss_cnt
);

    p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_valid);

    p_err_nocount_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> ($stable(l1_access_cnt) && $stable(l1_miss_cnt) && $stable(ll_miss_cnt)));

    p_miss_le_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        l1_miss_cnt <= l1_access_cnt);

    p_ready_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_l1_hit |-> req_ready);

    p_no_decrease_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_access_cnt >= $past(l1_access_cnt)) && (ll_miss_cnt >= $past(ll_miss_cnt)));

    p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_access_cnt == '1) |=> (l1_access_cnt == '1));

    p_flags_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_l1_hit && !rsp_ll_hit));

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_l1_hit |-> !rsp_ll_hit);

endmodule

bind lru_tag_sim lts_checker #(.CNT_W(CNT_W)) u_lts_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_l1_hit    (rsp_l1_hit),
    .rsp_ll_hit    (rsp_ll_hit),
    .rsp_err       (rsp_err),
    .l1_access_cnt (l1_access_cnt),
    .l1_miss_cnt   (l1_miss_cnt),
    .ll_miss_cnt   (ll_miss_cnt)
);

// File: tb/lru_tag_sim_bench.sv
`timescale 1ns/1ps
module lru_tag_sim_bench;

    localparam int ADDR_W = 16;
    localparam int SIZE_W = 8;
    localparam int CNT_W  = 4;
    localparam int NVEC   = 12;

    // vector: [31:16] address, [15:8] length, [7:4] class, [3:0] latency
    // class 0 = first-level hit, 1 = last-level hit, 2 = miss in both
    // first level: 4 sets x 2 ways, 16 B lines, tag = addr>>6 (R1)
    // last level : 8 sets x 4 ways, 16 B lines, tag = addr>>7 (R1)
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 8'd4, 4'd0, 4'd1},  // zero tag hits after reset
        {16'h0040, 8'd4, 4'd1, 4'd2},  // L1 miss, LL zero tag
        {16'h0000, 8'd1, 4'd0, 4'd1},  // hit in way 1, promoted
        {16'h0080, 8'd2, 4'd2, 4'd2},  // evicts tag 1 (LRU)
        {16'h0040, 8'd4, 4'd1, 4'd2},  // tag 1 was evicted
        {16'h0080, 8'd4, 4'd0, 4'd1},  // hit in way 1
        {16'h0000, 8'd4, 4'd1, 4'd2},  // tag 0 gone from L1
        {16'h001E, 8'd4, 4'd0, 4'd2},  // crossing, both hit
        {16'h013C, 8'd8, 4'd2, 4'd4},  // crossing with set wrap, both miss
        {16'h013C, 8'd8, 4'd0, 4'd2},  // same lines now hit
        {16'h0070, 8'd4, 4'd1, 4'd2},  // single line miss
        {16'h007E, 8'd4, 4'd1, 4'd4}   // first line hits, second misses
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              rsp_valid, rsp_l1_hit, rsp_ll_hit, rsp_err;
    logic [CNT_W-1:0]  l1_access_cnt, l1_miss_cnt, ll_miss_cnt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lru_tag_sim #(
        .ADDR_W    (ADDR_W),
        .SIZE_W    (SIZE_W),
        .L1_SIZE_B (128),
        .L1_LINE_B (16),
        .L1_WAYS   (2),
        .LL_SIZE_B (512),
        .LL_LINE_B (16),
        .LL_WAYS   (4),
        .CNT_W     (CNT_W)
    ) u_lru_tag_sim (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .rsp_valid     (rsp_valid),
        .rsp_l1_hit    (rsp_l1_hit),
        .rsp_ll_hit    (rsp_ll_hit),
        .rsp_err       (rsp_err),
        .l1_access_cnt (l1_access_cnt),
        .l1_miss_cnt   (l1_miss_cnt),
        .ll_miss_cnt   (ll_miss_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] s,
                          output int lat, output bit got_rsp, output bit got_err,
                          output bit l1h, output bit llh, output bit rdy1);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = s;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rdy1 = req_ready;
        lat  = 1;
        while (!rsp_valid && !rsp_err && lat < 16) begin
            @(negedge clk);
            lat++;
        end
        got_rsp = rsp_valid;
        got_err = rsp_err;
        l1h     = rsp_l1_hit;
        llh     = rsp_ll_hit;
    endtask

    task automatic check_counts(input string req, input int acc, input int m1, input int m2);
        @(negedge clk);
        chk(l1_access_cnt == CNT_W'(acc), req, "l1 access count", l1_access_cnt, acc);
        chk(l1_miss_cnt == CNT_W'(m1), req, "l1 miss count", l1_miss_cnt, m1);
        chk(ll_miss_cnt == CNT_W'(m2), req, "ll miss count", ll_miss_cnt, m2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        bit got_rsp, got_err, l1h, llh, rdy1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R2", "no response after reset", rsp_valid, 0);
        check_counts("R2", 0, 0, 0);

        // R1 R3 R4 R5 R7 R8 R9 R11: vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] cls;
            logic [3:0] exp_lat;
            cls     = VEC[i][7:4];
            exp_lat = VEC[i][3:0];
            do_req(VEC[i][31:16], VEC[i][15:8], lat, got_rsp, got_err, l1h, llh, rdy1);
            chk(got_rsp && !got_err, "R9", $sformatf("vec %0d response", i), got_rsp, 1);
            chk(lat == int'(exp_lat), "R9", $sformatf("vec %0d latency", i), lat, exp_lat);
            chk(l1h == (cls == 4'd0), "R3/R4/R5/R11", $sformatf("vec %0d l1 hit", i), l1h, cls == 4'd0);
            chk(llh == (cls == 4'd1), "R1/R7/R11", $sformatf("vec %0d ll hit", i), llh, cls == 4'd1);
            chk(rdy1 == ((cls == 4'd0) && (exp_lat == 4'd1)), "R8",
                $sformatf("vec %0d ready after accept", i), rdy1,
                (cls == 4'd0) && (exp_lat == 4'd1));
        end
        check_counts("R7", 12, 7, 2);

        // R6: three-set span is rejected without counting
        do_req(16'h0008, 8'd40, lat, got_rsp, got_err, l1h, llh, rdy1);
        chk(got_err == 1'b1, "R6", "error pulse", got_err, 1);
        chk(got_rsp == 1'b0, "R6", "no response on error", got_rsp, 0);
        chk(lat == 1, "R6", "error latency", lat, 1);
        check_counts("R6", 12, 7, 2);
        chk(rsp_err == 1'b0, "R6", "error is one cycle", rsp_err, 0);

        // R10: four more first-level hits push access count past 15
        for (int k = 0; k < 4; k++) begin
            do_req(16'h0070, 8'd1, lat, got_rsp, got_err, l1h, llh, rdy1);
            chk(got_rsp && l1h, "R10", "saturation run hit", l1h, 1);
        end
        check_counts("R10", 15, 7, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule